// File: doc/BRIEF.md
# Operand Address Generator

This unit sits between an instruction decoder and the datapath. For each operand, the decoder hands it a set of inputs in one cycle, marked by a `start` pulse:

- an addressing-mode code and an instruction-class code;
- the operand size;
- a register selector;
- a field of up to 32 bits with a width code;
- the current program counter.

From these the unit returns either an operand value (from a register or from the immediate field) or a memory address. For the auto-modify modes it also produces a register write-back. With every result it gives a flag that says whether the mode and field width are allowed for the instruction class.

Register values come from a combinational read port of the register file. Write-backs leave through a one-cycle write strobe. A second narrow read port supplies a bit index when a bit instruction takes its bit number from a register.

The memory-indirect mode fetches a pointer through a request/acknowledge read port. The unit stays busy until the pointer arrives.

Addresses that stand for instruction locations keep only their low 24 bits. This applies to PC-relative targets, fetched pointers, and any address computed while `prog` is high.

Top module: `ea_unit`

## Requirements
- R1: For every mode except memory indirect (mode 7), `valid` is high for exactly the cycle after the `start` cycle, and `result`, `is_addr`, `legal` and `bitno` are valid in that cycle.
- R2: Register direct (mode 0) gives an operand (`is_addr`=0) equal to the selected register masked to the operand size (osize 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits). Immediate (mode 5) gives the field masked to its width code (fwidth 0/1/2/3 = 8/16/24/32 bits).
- R3: Register indirect (mode 1) gives the register value as the address. Register indirect with displacement (mode 2) adds the field, sign-extended from its width, to the register.
- R4: Auto-modify (mode 3) uses step 1, 2 or 4 for osize 0, 1 or 2/3. With `predec`=0, the address is the old register value and the write-back is the old value plus the step. With `predec`=1, both the address and the write-back are the old value minus the step. The write-back appears with `valid` through `rf_we`, `rf_waddr`=`reg_sel` and `rf_wdata`.
- R5: Absolute (mode 4) gives the field sign-extended from its width code as the address.
- R6: PC-relative (mode 6) gives `pc` plus the field sign-extended from its width, with bits 31:24 cleared.
- R7: When `prog`=1, every address result has bits 31:24 cleared.
- R8: Memory indirect (mode 7) does the following. In the cycle after `start`, it raises `mem_req` and `busy`, with `mem_addr` equal to field bits 7:0 zero-extended. Both are held, with `mem_addr` stable, until `mem_ack`. In the cycle after `mem_ack`, `valid` is high with `result` equal to `mem_rdata` with bits 31:24 cleared, and `busy` and `mem_req` are low.
- R9: A `start` while `busy` is high is ignored: no `valid` appears until the pending fetch is acknowledged.
- R10: Class legality depends on `iclass`:

  | `iclass` | Class | Allowed modes |
  |---|---|---|
  | 0 | arithmetic/logic | 0, 5 |
  | 1 | data transfer | all except 6 and 7 |
  | 2 | bit | 0, 1, 4 |
  | 3 | flow | 1, 4, 6, 7 |

- R11: Width legality depends on the mode:

  | Mode | Allowed `fwidth` |
  |---|---|
  | 2 | 1 or 3 |
  | 5 | not 2 |
  | 6 | 0 or 1 |
  | 7 | 0 |
  | other modes | any |

  `legal` is high only when both R10 and R11 allow the operation.
- R12: No register write-back (`rf_we`) is issued for an illegal operation.
- R13: `bitno` equals `rf_bdata` (the register named by `bit_reg`) when `bit_from_reg`=1. Otherwise it equals `bit_imm`.
- R14: In reset and in the cycle after it, `valid`, `busy`, `mem_req` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, inputs sampled with it |
| mode | input | 3 | Addressing mode code |
| predec | input | 1 | Auto-modify direction: 1 = pre-decrement |
| iclass | input | 2 | Instruction class code |
| osize | input | 2 | Operand size code |
| fwidth | input | 2 | Field width code |
| field | input | 32 | Displacement, absolute or immediate field |
| reg_sel | input | 3 | Address/data register selector |
| pc | input | 32 | Current program counter |
| prog | input | 1 | Result is an instruction address |
| bit_from_reg | input | 1 | Bit number taken from a register |
| bit_imm | input | 3 | Immediate bit number |
| bit_reg | input | 3 | Register holding the bit number |
| rf_raddr | output | 3 | Register file read address |
| rf_rdata | input | 32 | Register file read data |
| rf_baddr | output | 3 | Bit-number register read address |
| rf_bdata | input | 3 | Low bits of that register |
| rf_we | output | 1 | Register write-back strobe |
| rf_waddr | output | 3 | Write-back register |
| rf_wdata | output | 32 | Write-back value |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer location |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_rdata | input | 32 | Pointer value |
| busy | output | 1 | Pointer fetch in progress |
| valid | output | 1 | Result strobe |
| is_addr | output | 1 | Result is an address (not an operand) |
| legal | output | 1 | Mode/width allowed for the class |
| result | output | 32 | Operand value or effective address |
| bitno | output | 3 | Bit number for bit instructions |

## Verification
Every mode except memory indirect registers its result once, so the bench raises `start` at a falling edge and samples all outputs at the next falling edge. At that edge the single rising edge in between has loaded `result`, `legal`, `bitno` and the write-back.

For memory indirect, the request is checked one falling edge after `start`. It is then checked at each falling edge while `mem_ack` is withheld for a random number of cycles. The pointer result is checked at the falling edge that follows the acknowledge cycle.

Expected values come from bench functions applied to a bench-owned register model. That model is updated from the expected write-back, never from the design's output.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        AM_REG   = 3'd0,
        AM_IND   = 3'd1,
        AM_DISP  = 3'd2,
        AM_AUTO  = 3'd3,
        AM_ABS   = 3'd4,
        AM_IMM   = 3'd5,
        AM_PCREL = 3'd6,
        AM_MIND  = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        IC_ALU  = 2'd0,
        IC_MOVE = 2'd1,
        IC_BIT  = 2'd2,
        IC_FLOW = 2'd3
    } ic_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } st_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            is_addr;
        logic            wb_en;
        logic [XLEN-1:0] wb_val;
    } calc_t;

    // sign-extend a field from the width selected by a 2-bit code (8/16/24/32)
    function automatic logic [XLEN-1:0] sext_field(logic [XLEN-1:0] f, logic [1:0] w);
        case (w)
            2'd0:    return {{(XLEN-8){f[7]}},   f[7:0]};
            2'd1:    return {{(XLEN-16){f[15]}}, f[15:0]};
            2'd2:    return {{(XLEN-24){f[23]}}, f[23:0]};
            default: return f;
        endcase
    endfunction

    // keep the low bits selected by a 2-bit width code, clear the rest
    function automatic logic [XLEN-1:0] zext_field(logic [XLEN-1:0] f, logic [1:0] w);
        case (w)
            2'd0:    return {{(XLEN-8){1'b0}},  f[7:0]};
            2'd1:    return {{(XLEN-16){1'b0}}, f[15:0]};
            2'd2:    return {{(XLEN-24){1'b0}}, f[23:0]};
            default: return f;
        endcase
    endfunction

    // operand size code to byte step / lane mask
    function automatic logic [XLEN-1:0] size_step(logic [1:0] s);
        case (s)
            2'd0:    return XLEN'(1);
            2'd1:    return XLEN'(2);
            default: return XLEN'(4);
        endcase
    endfunction

    function automatic logic [XLEN-1:0] size_lane(logic [XLEN-1:0] v, logic [1:0] s);
        case (s)
            2'd0:    return {{(XLEN-8){1'b0}},  v[7:0]};
            2'd1:    return {{(XLEN-16){1'b0}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/ea_legal.sv
module ea_legal
    import ea_pkg::*;
(
    input  am_e        mode,
    input  ic_e        iclass,
    input  logic [1:0] fwidth,
    output logic       ok
);
    logic class_ok;
    logic width_ok;

    always_comb begin
        case (iclass)
            IC_ALU:  class_ok = (mode == AM_REG) || (mode == AM_IMM);
            IC_MOVE: class_ok = (mode != AM_PCREL) && (mode != AM_MIND);
            IC_BIT:  class_ok = (mode == AM_REG) || (mode == AM_IND) || (mode == AM_ABS);
            default: class_ok = (mode == AM_IND) || (mode == AM_ABS) ||
                                (mode == AM_PCREL) || (mode == AM_MIND);
        endcase
        case (mode)
            AM_DISP:  width_ok = fwidth[0];
            AM_IMM:   width_ok = (fwidth != 2'd2);
            AM_PCREL: width_ok = !fwidth[1];
            AM_MIND:  width_ok = (fwidth == 2'd0);
            default:  width_ok = 1'b1;
        endcase
        ok = class_ok && width_ok;
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int PROG_BITS = 24
) (
    input  am_e             mode,
    input  logic            predec,
    input  logic [1:0]      osize,
    input  logic [1:0]      fwidth,
    input  logic [XLEN-1:0] field,
    input  logic [XLEN-1:0] pc,
    input  logic            prog,
    input  logic [XLEN-1:0] rval,
    output calc_t           res
);
    localparam logic [XLEN-1:0] PMASK = {{(XLEN-PROG_BITS){1'b0}}, {PROG_BITS{1'b1}}};

    logic [XLEN-1:0] off;
    logic [XLEN-1:0] step;

    always_comb begin
        off  = sext_field(field, fwidth);
        step = size_step(osize);
        res  = '0;
        case (mode)
            AM_REG:   res.value = size_lane(rval, osize);
            AM_IND:   begin res.value = rval;       res.is_addr = 1'b1; end
            AM_DISP:  begin res.value = rval + off; res.is_addr = 1'b1; end
            AM_AUTO: begin
                res.is_addr = 1'b1;
                res.wb_en   = 1'b1;
                if (predec) begin
                    res.value  = rval - step;
                    res.wb_val = rval - step;
                end else begin
                    res.value  = rval;
                    res.wb_val = rval + step;
                end
            end
            AM_ABS:   begin res.value = off;        res.is_addr = 1'b1; end
            AM_IMM:   res.value = zext_field(field, fwidth);
            AM_PCREL: begin res.value = pc + off;   res.is_addr = 1'b1; end
            default:  begin res.value = {{(XLEN-8){1'b0}}, field[7:0]}; res.is_addr = 1'b1; end
        endcase
        if (res.is_addr && (mode != AM_MIND) && (prog || mode == AM_PCREL))
            res.value = res.value & PMASK;
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int PROG_BITS = 24,
    localparam int RW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic            predec,
    input  logic [1:0]      iclass,
    input  logic [1:0]      osize,
    input  logic [1:0]      fwidth,
    input  logic [31:0]     field,
    input  logic [RW-1:0]   reg_sel,
    input  logic [31:0]     pc,
    input  logic            prog,
    input  logic            bit_from_reg,
    input  logic [2:0]      bit_imm,
    input  logic [RW-1:0]   bit_reg,
    output logic [RW-1:0]   rf_raddr,
    input  logic [31:0]     rf_rdata,
    output logic [RW-1:0]   rf_baddr,
    input  logic [2:0]      rf_bdata,
    output logic            rf_we,
    output logic [RW-1:0]   rf_waddr,
    output logic [31:0]     rf_wdata,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            busy,
    output logic            valid,
    output logic            is_addr,
    output logic            legal,
    output logic [31:0]     result,
    output logic [2:0]      bitno
);
    localparam logic [XLEN-1:0] PMASK = {{(XLEN-PROG_BITS){1'b0}}, {PROG_BITS{1'b1}}};

    am_e   mode_c;
    calc_t calc;
    logic  legal_c;
    st_e   st;

    assign mode_c   = am_e'(mode);
    assign rf_raddr = reg_sel;
    assign rf_baddr = bit_reg;

    ea_legal i_legal (
        .mode   (mode_c),
        .iclass (ic_e'(iclass)),
        .fwidth (fwidth),
        .ok     (legal_c)
    );

    ea_calc #(.PROG_BITS(PROG_BITS)) i_calc (
        .mode   (mode_c),
        .predec (predec),
        .osize  (osize),
        .fwidth (fwidth),
        .field  (field),
        .pc     (pc),
        .prog   (prog),
        .rval   (rf_rdata),
        .res    (calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            busy     <= 1'b0;
            valid    <= 1'b0;
            is_addr  <= 1'b0;
            legal    <= 1'b0;
            result   <= '0;
            bitno    <= '0;
            rf_we    <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else begin
            valid <= 1'b0;
            rf_we <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        legal   <= legal_c;
                        bitno   <= bit_from_reg ? rf_bdata : bit_imm;
                        is_addr <= calc.is_addr;
                        if (mode_c == AM_MIND) begin
                            st       <= ST_WAIT;
                            busy     <= 1'b1;
                            mem_req  <= 1'b1;
                            mem_addr <= calc.value;
                        end else begin
                            valid    <= 1'b1;
                            result   <= calc.value;
                            rf_we    <= calc.wb_en && legal_c;
                            rf_waddr <= reg_sel;
                            rf_wdata <= calc.wb_val;
                        end
                    end
                end
                default: begin
                    if (mem_ack) begin
                        st      <= ST_IDLE;
                        busy    <= 1'b0;
                        mem_req <= 1'b0;
                        valid   <= 1'b1;
                        result  <= mem_rdata & PMASK;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int PROG_BITS = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        valid,
    input logic        legal,
    input logic        rf_we,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] result
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R8
    ack_result_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (valid && !busy && ((result >> PROG_BITS) == 0)));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> !valid);

    // R12
    wb_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (legal && valid));

    // R1
    start_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (valid || busy));
endmodule

bind ea_unit ea_unit_chk #(.PROG_BITS(PROG_BITS)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .valid    (valid),
    .legal    (legal),
    .rf_we    (rf_we),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .result   (result)
);

// File: tb/test_ea_unit.sv
`timescale 1ns/1ps
module test_ea_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic        predec;
    logic [1:0]  iclass;
    logic [1:0]  osize;
    logic [1:0]  fwidth;
    logic [31:0] field;
    logic [2:0]  reg_sel;
    logic [31:0] pc;
    logic        prog;
    logic        bit_from_reg;
    logic [2:0]  bit_imm;
    logic [2:0]  bit_reg;
    logic [2:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic [2:0]  rf_baddr;
    logic [2:0]  rf_bdata;
    logic        rf_we;
    logic [2:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        busy;
    logic        valid;
    logic        is_addr;
    logic        legal;
    logic [31:0] result;
    logic [2:0]  bitno;

    logic [31:0] regs [8];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int ack_delay = 1;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];
    assign rf_bdata = regs[rf_baddr][2:0];

    ea_unit i_ea_unit (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] x_sext(logic [31:0] f, logic [1:0] w);
        int sh;
        sh = 24 - 8 * int'(w);
        return 32'($signed(f << sh) >>> sh);
    endfunction

    function automatic logic [31:0] x_keep(logic [31:0] v, int bits);
        return (bits >= 32) ? v : (v & ((32'd1 << bits) - 32'd1));
    endfunction

    function automatic int x_step(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit x_legal(int m, int c, int w);
        bit cok, wok;
        case (c)
            0:       cok = (m == 0) || (m == 5);
            1:       cok = (m != 6) && (m != 7);
            2:       cok = (m == 0) || (m == 1) || (m == 4);
            default: cok = (m == 1) || (m == 4) || (m == 6) || (m == 7);
        endcase
        case (m)
            2:       wok = (w == 1) || (w == 3);
            5:       wok = (w != 2);
            6:       wok = (w < 2);
            7:       wok = (w == 0);
            default: wok = 1;
        endcase
        return cok && wok;
    endfunction

    function automatic string x_tag(int m);
        case (m)
            0, 5:    return "R2";
            1, 2:    return "R3";
            3:       return "R4";
            4:       return "R5";
            6:       return "R6";
            default: return "R8";
        endcase
    endfunction

    // run one request with the current input variables; checks all results
    task automatic run_op();
        logic [31:0] rv, exp_v, exp_wb, ptr;
        bit          exp_addr, exp_l, exp_we;
        logic [2:0]  exp_bn;
        int          m;
        m      = int'(mode);
        rv     = regs[reg_sel];
        exp_l  = x_legal(m, int'(iclass), int'(fwidth));
        exp_bn = bit_from_reg ? regs[bit_reg][2:0] : bit_imm;
        exp_we = 0;
        exp_wb = 32'h0;
        exp_addr = !(m == 0 || m == 5);
        case (m)
            0: exp_v = x_keep(rv, (osize == 0) ? 8 : (osize == 1) ? 16 : 32);
            1: exp_v = rv;
            2: exp_v = rv + x_sext(field, fwidth);
            3: begin
                exp_we = exp_l;
                if (predec) begin
                    exp_v = rv - 32'(x_step(osize));
                    exp_wb = exp_v;
                end else begin
                    exp_v = rv;
                    exp_wb = rv + 32'(x_step(osize));
                end
            end
            4: exp_v = x_sext(field, fwidth);
            5: exp_v = x_keep(field, 8 * (int'(fwidth) + 1));
            6: exp_v = x_keep(pc + x_sext(field, fwidth), 24);
            default: exp_v = 32'h0;
        endcase
        if (prog && exp_addr) exp_v = x_keep(exp_v, 24);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (m == 7) begin
            check("R8 busy", 32'(busy), 32'd1);
            check("R8 req", 32'(mem_req), 32'd1);
            check("R8 ptr addr", mem_addr, {24'h0, field[7:0]});
            for (int k = 0; k < ack_delay; k++) begin
                start = 1'b1;
                @(negedge clk);
                check("R9 no valid while busy", 32'(valid), 32'd0);
                check("R8 req held", 32'(mem_req), 32'd1);
            end
            start     = 1'b0;
            ptr       = {$urandom, 1'b0} ^ 32'hA500_0000;
            mem_ack   = 1'b1;
            mem_rdata = ptr;
            @(negedge clk);
            mem_ack   = 1'b0;
            check("R8 valid", 32'(valid), 32'd1);
            check("R8 pointer", result, x_keep(ptr, 24));
            check("R8 idle", 32'({busy, mem_req}), 32'd0);
        end else begin
            check("R1 valid", 32'(valid), 32'd1);
            check(x_tag(m), result, exp_v);
        end
        check(x_tag(m), 32'(is_addr), 32'(exp_addr));
        check("R10 R11 legal", 32'(legal), 32'(exp_l));
        check("R13 bitno", 32'(bitno), 32'(exp_bn));
        check(exp_l ? "R4 we" : "R12 we", 32'(rf_we), 32'(exp_we));
        if (exp_we) begin
            check("R4 waddr", 32'(rf_waddr), 32'(reg_sel));
            check("R4 wdata", rf_wdata, exp_wb);
            regs[reg_sel] = exp_wb;
        end
    endtask

    task automatic set_op(int m, int c, int s, int w, logic [31:0] f, int r, bit pd, bit pg);
        mode = 3'(m); iclass = 2'(c); osize = 2'(s); fwidth = 2'(w);
        field = f; reg_sel = 3'(r); predec = pd; prog = pg;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) regs[i] = 32'h0100_0000 * i + 32'h1000;
        rst = 1'b1; start = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
        pc = 32'h0000_4000; bit_from_reg = 0; bit_imm = 3'd5; bit_reg = 3'd0;
        set_op(0, 0, 2, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check("R14 reset", 32'({valid, busy, mem_req, rf_we}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R14 after reset", 32'({valid, busy, mem_req, rf_we}), 32'd0);

        // post-increment by each size, then pre-decrement (R4)
        regs[3] = 32'h0000_2000;
        for (int s = 0; s < 3; s++) begin set_op(3, 1, s, 0, 0, 3, 0, 0); run_op(); end
        for (int s = 0; s < 3; s++) begin set_op(3, 1, s, 0, 0, 3, 1, 0); run_op(); end
        // absolute widths, negative values (R5)
        for (int w = 0; w < 4; w++) begin set_op(4, 1, 2, w, 32'hFF80_8080, 0, 0, 0); run_op(); end
        // PC-relative wrap and 24-bit cut (R6)
        pc = 32'hFF00_0010;
        set_op(6, 3, 2, 0, 32'h0000_00FE, 0, 0, 0); run_op();
        set_op(6, 3, 2, 1, 32'h0000_8000, 0, 0, 0); run_op();
        // instruction-address masking of absolute (R7)
        set_op(4, 3, 2, 3, 32'hABCD_EF12, 0, 0, 1); run_op();
        // memory indirect with delayed ack and start while busy (R8, R9)
        ack_delay = 4;
        set_op(7, 3, 2, 0, 32'h1234_56C3, 0, 0, 0); run_op();
        ack_delay = 0;
        set_op(7, 3, 2, 0, 32'h0000_0010, 0, 0, 1); run_op();
        // illegal auto-modify under arithmetic class: no write-back (R12)
        set_op(3, 0, 2, 0, 0, 5, 0, 0); run_op();
        // bit number from register (R13)
        bit_from_reg = 1; bit_reg = 3'd6; regs[6] = 32'h0000_0003;
        set_op(1, 2, 0, 0, 0, 2, 0, 0); run_op();
        bit_from_reg = 0;
        // class legality sweep (R10)
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 8; m++) begin
                set_op(m, c, 1, (m == 7) ? 0 : 1, 32'h0000_0042, 1, 0, 0);
                ack_delay = 1;
                run_op();
            end
        // width legality sweep (R11)
        for (int w = 0; w < 4; w++) begin
            set_op(2, 1, 2, w, 32'h8000_0004, 2, 0, 0); run_op();
            set_op(5, 0, 2, w, 32'h89AB_CDEF, 2, 0, 0); run_op();
            set_op(6, 3, 2, w, 32'h0000_7F00, 2, 0, 0); run_op();
        end
        // constrained random
        for (int n = 0; n < 400; n++) begin
            int m;
            m = int'($urandom_range(0, 7));
            pc = $urandom;
            bit_from_reg = 1'($urandom); bit_imm = 3'($urandom); bit_reg = 3'($urandom);
            ack_delay = int'($urandom_range(0, 3));
            set_op(m, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                   (m == 7) ? 0 : int'($urandom_range(0, 3)), $urandom,
                   int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom));
            run_op();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule